// File: doc/BRIEF.md
# Two-Slot Elastic Link Stage

This block is one pipeline stage on a network-on-chip link. It can hold up to two flits. It uses a valid/ready handshake on its upstream side and on its downstream side. A flit crosses an interface only at a rising clock edge where both valid and ready on that interface are high.

Stages can be placed back to back along a wire. The chain then acts as a FIFO spread along the link, with a depth equal to the sum of the stage depths, so the receiving router needs no input FIFO.

The two storage places are two separately enabled registers. One is the head register, which drives the output. The other is a spare register, which takes a flit only while the head is occupied and stalled. All outputs come straight from registers, so no path runs combinationally from input to output.

Top module: `link_elastic_stage`

## Requirements
- R1: The stage holds at most two flits. With downstream ready held low, it accepts exactly two flits and then refuses further ones.
- R2: `up_ready` is high exactly when fewer than two flits are held.
- R3: `dn_valid` is high exactly when at least one flit is held, and `dn_data` then carries the oldest held flit.
- R4: A flit is taken from upstream only at a rising edge where `up_valid` and `up_ready` are both high. A flit leaves downstream only at an edge where `dn_valid` and `dn_ready` are both high. Flits leave in the order they arrived, and none is lost or duplicated.
- R5: While one flit is held, a new flit can be accepted at the same edge that the held one is released. The new flit is presented at the next cycle, and `up_ready` stays high.
- R6: A flit accepted into an empty stage appears on `dn_data` with `dn_valid` high in the cycle after the accepting edge, and not in the same cycle.
- R7: Reset is synchronous and active low. At an edge with `rst_n` low, both slots are emptied. Afterwards `dn_valid` is low and `up_ready` is high.
- R8: While `dn_valid` is high and `dn_ready` is low, `dn_data` and `dn_valid` hold their values at the next edge.
- R9: Two stages connected back to back accept exactly four flits while the far end is stalled, and deliver them in order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| up_data | input | FLIT_W | Flit offered by the upstream side |
| up_valid | input | 1 | Upstream flit is valid |
| up_ready | output | 1 | Stage has at least one free slot |
| dn_data | output | FLIT_W | Oldest held flit |
| dn_valid | output | 1 | `dn_data` carries a held flit |
| dn_ready | input | 1 | Downstream side can take the flit |

## Verification
Every output comes from registers. An acceptance or a release therefore changes `up_ready`, `dn_valid` and `dn_data` exactly one edge later, and a reset edge empties the stage one edge after `rst_n` is seen low. The bench drives inputs and compares outputs at the falling edge. Its reference queue is updated at the rising edge in between. Each comparison therefore sees the result of the handshake one edge earlier, which is the one-cycle latency given in R5 and R6. The chained test counts acceptances at falling edges while the far end is stalled, then drains the chain and checks the order of the flits that come out.

// File: rtl/elastic_pkg.sv
`timescale 1ns/1ps
// Package: shared types for the elastic link stage.
// Assumes: at most two flits are held per stage.
package elastic_pkg;
    localparam int SLOT_COUNT = 2;
    localparam int HEAD_IDX   = 0;
    localparam int SPARE_IDX  = 1;

    typedef enum logic [1:0] {
        OCC_NONE = 2'd0,
        OCC_ONE  = 2'd1,
        OCC_TWO  = 2'd2
    } occ_e;
endpackage

// File: rtl/es_slot.sv
`timescale 1ns/1ps
// Module: es_slot
// One flit storage location with its own load enable. It stands in for one
// of the two latches in a flip-flop position.
// Assumes: load is a single-cycle strobe from the controller.
module es_slot #(
    parameter int FLIT_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [FLIT_W-1:0] d,
    output logic [FLIT_W-1:0] q
);
    // capture d when enabled; clear on reset
    always_ff @(posedge clk) begin
        if (!rst_n)    q <= '0;
        else if (load) q <= d;
    end
endmodule

// File: rtl/es_ctrl.sv
`timescale 1ns/1ps
// Module: es_ctrl
// Occupancy tracker and slot enable logic for the two-slot stage.
// The head slot drives the output. The spare slot fills only when the head is
// held and stalled. The spare is never occupied while the head is empty.
// Assumes: synchronous active-low reset.
module es_ctrl
    import elastic_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic up_valid,
    input  logic dn_ready,
    output logic up_ready,
    output logic dn_valid,
    output logic load_head,
    output logic load_spare,
    output logic head_from_spare
);
    occ_e occ_q, occ_d;
    logic accept, release_w;

    // handshake outputs depend on registered occupancy only
    always_comb begin
        up_ready  = (occ_q != OCC_TWO);
        dn_valid  = (occ_q != OCC_NONE);
        accept    = up_valid && up_ready;
        release_w = dn_valid && dn_ready;
    end

    // slot enables and next occupancy
    always_comb begin
        load_head       = 1'b0;
        load_spare      = 1'b0;
        head_from_spare = 1'b0;
        occ_d           = occ_q;
        unique case (occ_q)
            OCC_NONE: begin
                load_head = accept;
                if (accept) occ_d = OCC_ONE;
            end
            OCC_ONE: begin
                if (accept && release_w) begin
                    load_head = 1'b1;
                end else if (accept) begin
                    load_spare = 1'b1;
                    occ_d      = OCC_TWO;
                end else if (release_w) begin
                    occ_d = OCC_NONE;
                end
            end
            OCC_TWO: begin
                if (release_w) begin
                    load_head       = 1'b1;
                    head_from_spare = 1'b1;
                    occ_d           = OCC_ONE;
                end
            end
            default: occ_d = OCC_NONE;
        endcase
    end

    // occupancy register
    always_ff @(posedge clk) begin
        if (!rst_n) occ_q <= OCC_NONE;
        else        occ_q <= occ_d;
    end
endmodule

// File: rtl/link_elastic_stage.sv
`timescale 1ns/1ps
// Module: link_elastic_stage
// A two-slot elastic buffer stage for a network-on-chip link, with a
// valid/ready handshake on both sides. All outputs are registered.
// Assumes: a single clock and a synchronous active-low reset.
module link_elastic_stage
    import elastic_pkg::*;
#(
    parameter int FLIT_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [FLIT_W-1:0] up_data,
    input  logic              up_valid,
    output logic              up_ready,
    output logic [FLIT_W-1:0] dn_data,
    output logic              dn_valid,
    input  logic              dn_ready
);
    logic                          load_head, load_spare, head_from_spare;
    logic [SLOT_COUNT-1:0]         slot_load;
    logic [SLOT_COUNT-1:0][FLIT_W-1:0] slot_d;
    logic [SLOT_COUNT-1:0][FLIT_W-1:0] slot_q;

    es_ctrl u_ctrl (
        .clk             (clk),
        .rst_n           (rst_n),
        .up_valid        (up_valid),
        .dn_ready        (dn_ready),
        .up_ready        (up_ready),
        .dn_valid        (dn_valid),
        .load_head       (load_head),
        .load_spare      (load_spare),
        .head_from_spare (head_from_spare)
    );

    // route enables and data sources to the slots
    always_comb begin
        slot_load[HEAD_IDX]  = load_head;
        slot_load[SPARE_IDX] = load_spare;
        slot_d[HEAD_IDX]     = head_from_spare ? slot_q[SPARE_IDX] : up_data;
        slot_d[SPARE_IDX]    = up_data;
    end

    for (genvar i = 0; i < SLOT_COUNT; i++) begin : g_slot
        es_slot #(.FLIT_W(FLIT_W)) u_slot (
            .clk   (clk),
            .rst_n (rst_n),
            .load  (slot_load[i]),
            .d     (slot_d[i]),
            .q     (slot_q[i])
        );
    end

    assign dn_data = slot_q[HEAD_IDX];
endmodule

// File: rtl/link_elastic_stage_checker.sv
`timescale 1ns/1ps
// Module: link_elastic_stage_checker
// Port-level properties of the elastic stage. It keeps its own occupancy
// count, built only from the handshakes seen at the ports.
// Assumes: bound to link_elastic_stage.
module link_elastic_stage_checker #(
    parameter int FLIT_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [FLIT_W-1:0] up_data,
    input logic              up_valid,
    input logic              up_ready,
    input logic [FLIT_W-1:0] dn_data,
    input logic              dn_valid,
    input logic              dn_ready
);
    logic [1:0] held;
    logic       acc, rel;
    logic       seen_edge, rst_was_low;

    assign acc = up_valid && up_ready;
    assign rel = dn_valid && dn_ready;

    // count the flits held, from port handshakes only
    always_ff @(posedge clk) begin
        if (!rst_n) held <= 2'd0;
        else        held <= held + {1'b0, acc} - {1'b0, rel};
    end

    // remember whether the previous edge saw reset
    always_ff @(posedge clk) begin
        seen_edge   <= 1'b1;
        rst_was_low <= !rst_n;
        if (seen_edge && rst_was_low) begin
            assert_reset_empty_R7: assert (!dn_valid && up_ready);
        end
    end

    assert_cap_R1: assert property (@(posedge clk) disable iff (!rst_n)
        held <= 2'd2);
    assert_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
        up_ready == (held < 2'd2));
    assert_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
        dn_valid == (held != 2'd0));
    assert_swap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (held == 2'd1 && acc && rel) |=> (dn_valid && up_ready && dn_data == $past(up_data)));
    assert_no_pass_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && !dn_valid) |=> (dn_valid && dn_data == $past(up_data)));
    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_valid && !dn_ready) |=> (dn_valid && $stable(dn_data)));
endmodule

bind link_elastic_stage link_elastic_stage_checker #(.FLIT_W(FLIT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .up_data  (up_data),
    .up_valid (up_valid),
    .up_ready (up_ready),
    .dn_data  (dn_data),
    .dn_valid (dn_valid),
    .dn_ready (dn_ready)
);

// File: tb/link_elastic_stage_tb_top.sv
`timescale 1ns/1ps
// Bench: queue reference model compared at every falling edge; a second
// part checks two chained stages.
module link_elastic_stage_tb_top;
    localparam int W = 8;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic         rst_n;
    logic [W-1:0] up_data, dn_data;
    logic         up_valid, up_ready, dn_valid, dn_ready;

    logic [W-1:0] c_up_data, c_mid_data, c_dn_data;
    logic         c_up_valid, c_up_ready, c_mid_valid, c_mid_ready;
    logic         c_dn_valid, c_dn_ready;

    int           n_chk = 0;
    int           n_fail = 0;
    logic [W-1:0] mq[$];
    logic [W-1:0] next_val = 8'h10;

    link_elastic_stage #(.FLIT_W(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .up_data(up_data), .up_valid(up_valid),
        .up_ready(up_ready), .dn_data(dn_data), .dn_valid(dn_valid), .dn_ready(dn_ready)
    );

    link_elastic_stage #(.FLIT_W(W)) ch0_i (
        .clk(clk), .rst_n(rst_n), .up_data(c_up_data), .up_valid(c_up_valid),
        .up_ready(c_up_ready), .dn_data(c_mid_data), .dn_valid(c_mid_valid), .dn_ready(c_mid_ready)
    );

    link_elastic_stage #(.FLIT_W(W)) ch1_i (
        .clk(clk), .rst_n(rst_n), .up_data(c_mid_data), .up_valid(c_mid_valid),
        .up_ready(c_mid_ready), .dn_data(c_dn_data), .dn_valid(c_dn_valid), .dn_ready(c_dn_ready)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // compare outputs with the model, drive one cycle, update the model at the edge
    task automatic step(input string req, input bit v, input bit r, input bit rst);
        bit acc, rel;
        check(req, "dn_valid", int'(dn_valid), int'(mq.size() != 0));
        check(req, "up_ready", int'(up_ready), int'(mq.size() < 2));
        if (mq.size() != 0) check(req, "dn_data", int'(dn_data), int'(mq[0]));
        rst_n    = !rst;
        up_valid = v;
        up_data  = next_val;
        dn_ready = r;
        acc = v && (mq.size() < 2);
        rel = r && (mq.size() != 0);
        @(posedge clk);
        if (rst) mq.delete();
        else begin
            if (rel) void'(mq.pop_front());
            if (acc) begin
                mq.push_back(next_val);
                next_val = next_val + 8'd1;
            end
        end
        @(negedge clk);
    endtask

    initial begin : watchdog
        #2000000;
        n_fail++;
        $display("FAIL watchdog R4 actual=timeout expected=completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        int acc_cnt;
        logic [W-1:0] held_data;
        rst_n = 1'b0; up_valid = 1'b0; dn_ready = 1'b0; up_data = '0;
        c_up_valid = 1'b0; c_up_data = '0; c_dn_ready = 1'b0;
        @(posedge clk);
        @(negedge clk);
        // R7: reset state
        check("R7", "dn_valid after reset", int'(dn_valid), 0);
        check("R7", "up_ready after reset", int'(up_ready), 1);
        step("R7", 1'b1, 1'b0, 1'b1);
        step("R7", 1'b0, 1'b0, 1'b0);

        // R1, R2: fill while stalled; only two flits taken
        for (int i = 0; i < 4; i++) step("R1", 1'b1, 1'b0, 1'b0);
        check("R1", "held flits", mq.size(), 2);
        check("R2", "up_ready when full", int'(up_ready), 0);
        // R8: output frozen under stall
        held_data = dn_data;
        step("R8", 1'b1, 1'b0, 1'b0);
        check("R8", "dn_data stable", int'(dn_data), int'(held_data));
        check("R8", "dn_valid stable", int'(dn_valid), 1);

        // R3: drain one by one
        for (int i = 0; i < 3; i++) step("R3", 1'b0, 1'b1, 1'b0);

        // R6: accept into an empty stage, visible only next cycle
        step("R6", 1'b1, 1'b0, 1'b0);
        check("R6", "dn_valid after accept", int'(dn_valid), 1);
        step("R6", 1'b0, 1'b1, 1'b0);

        // R5: stream with one flit held, accept and release each edge
        step("R5", 1'b1, 1'b0, 1'b0);
        for (int i = 0; i < 20; i++) step("R5", 1'b1, 1'b1, 1'b0);
        check("R5", "occupancy during stream", mq.size(), 1);

        // R4: mixed handshake patterns
        for (int i = 0; i < 400; i++)
            step("R4", bit'($urandom_range(0, 1)), bit'($urandom_range(0, 1)), 1'b0);

        // R7: reset with content held
        step("R7", 1'b1, 1'b0, 1'b0);
        step("R7", 1'b1, 1'b0, 1'b0);
        step("R7", 1'b0, 1'b0, 1'b1);
        check("R7", "dn_valid after mid reset", int'(dn_valid), 0);
        step("R7", 1'b0, 1'b0, 1'b0);

        // R9: two chained stages hold four flits in order
        acc_cnt = 0;
        c_dn_ready = 1'b0;
        for (int i = 0; i < 8; i++) begin
            c_up_valid = 1'b1;
            c_up_data  = 8'hA0 + 8'(acc_cnt);
            if (c_up_ready) acc_cnt++;
            @(posedge clk);
            @(negedge clk);
        end
        c_up_valid = 1'b0;
        check("R9", "chain accepted", acc_cnt, 4);
        acc_cnt = 0;
        c_dn_ready = 1'b1;
        for (int i = 0; i < 10; i++) begin
            if (c_dn_valid) begin
                check("R9", "chain order", int'(c_dn_data), int'(8'hA0 + 8'(acc_cnt)));
                acc_cnt++;
            end
            @(posedge clk);
            @(negedge clk);
        end
        check("R9", "chain delivered", acc_cnt, 4);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule